// File: doc/BRIEF.md
# Serial Register Front End for a Current-Loop DAC

This block is the digital slave side of a current-output converter's serial port. A host shifts 24-bit frames into it in SPI mode 0 while holding chip select low. Each frame carries a read flag, a register address and a 16-bit data field. Writes update a small register file: DAC data, control, offset and gain. Some addresses carry a command and no storage: load, alarm force, reset, conversion start and no-op. One address behaves differently by direction. A write to it moves the DAC data register into the output code. A read of it returns the fault status word.

A read is answered one frame later. The response shifts out on `miso` during the next frame and sits in its low 16 bits. The fault status word combines a sticky serial-error flag with seven live condition inputs. A fault pin stays high whenever any of the severe conditions is present, and no mask can hide it.

The serial pins are sampled by the system clock. `sclk` must therefore run several times slower than `clk`. The frame engine is a three-state machine. FR_IDLE waits for chip select to fall and loads the response shifter. FR_SHIFT captures `mosi` on rising `sclk`, advances `miso` on falling `sclk`, and leaves when chip select rises. FR_DONE lasts one cycle, judges the bit count and returns to FR_IDLE.

Top module: `spi_dac_regif`

## Requirements
- R1: A frame is the bits clocked in on rising `sclk` between a falling and a rising `cs_n`, first bit most significant. Bit 23 is the read flag, bits 22:16 are the address and bits 15:0 are the data. A write to 0x01 stores DAC data, to 0x03 stores the offset and to 0x04 stores the gain. A write to 0x02 stores only control bits 12, 11, 9, 8, 7 and 6, and the other bits read back as 0.
- R2: `miso` shifts out MSB first, valid before each rising `sclk`. In the frame after a read request it carries 0x00 in bits 23:16 and the addressed register in bits 15:0. In the frame after any accepted non-read frame it carries all zeros.
- R3: A write to 0x05 copies the DAC data register into `dac_code`. Writes to 0x01 alone do not change `dac_code`.
- R4: A read of 0x05 returns this fault word: bit 15 is the sticky serial-error flag, bits 14:8 are `fault_in[6:0]`, and bits 7:0 are 0. The `fault_in` order from bit 6 down is checksum error, over-current, under-current, over 140 C, over 100 C, 6 V undervoltage and 12 V undervoltage.
- R5: `fault_out` is high exactly when the serial-error flag or any of `fault_in[6:3]` is set. `fault_in[2:0]` never raise it.
- R6: A frame whose bit count is not 24 changes no register and sets the serial-error flag.
- R7: A write to 0x07 restores the reset values: DAC data 0, control 0, offset 0x8000, gain 0xFFFF, `dac_code` 0, `force_alarm` 0. It also clears the serial-error flag.
- R8: A write to 0x06 sets `force_alarm` to data bit 0. A write to 0x08 pulses `conv_start` for exactly one cycle. A write to 0x09 changes nothing.
- R9: A read of any address other than 0x01 to 0x05 returns 0x0000. A write to an unmapped address changes no register.
- R10: After reset `miso`, `fault_out`, `force_alarm`, `conv_start` and `dac_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| fault_in | input | 7 | Live fault conditions: checksum, over-current, under-current, >140 C, >100 C, 6 V UV, 12 V UV |
| miso | output | 1 | Serial data to the host |
| fault_out | output | 1 | Unmaskable fault pin |
| dac_code | output | 16 | Code currently applied to the converter |
| force_alarm | output | 1 | Alarm-current force level |
| conv_start | output | 1 | One-cycle conversion start strobe |

## Verification
Assertions check on every cycle that FR_DONE always returns to FR_IDLE and that the bit counter stays saturated. They also check that a bad frame sets the serial-error flag on the next edge, and that a load copies the data register to `dac_code`. Further checks cover the restore values after a reset command, the single-cycle conversion strobe and the over-current path to the fault pin. Only the bench scenarios show the one-frame read latency and the masking of control bits. The same holds for the fault word layout across all 128 condition patterns, and for short and long frames being discarded.

// File: rtl/spi_dac_pkg.sv
package spi_dac_pkg;
    localparam int FRAME_BITS = 24;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 7;
    localparam int FLT_W      = 7;
    localparam int CMD_W      = FRAME_BITS - DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    localparam logic [ADDR_W-1:0] A_DATA  = 7'h01;
    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h02;
    localparam logic [ADDR_W-1:0] A_OFFS  = 7'h03;
    localparam logic [ADDR_W-1:0] A_GAIN  = 7'h04;
    localparam logic [ADDR_W-1:0] A_LDFLT = 7'h05;
    localparam logic [ADDR_W-1:0] A_ALARM = 7'h06;
    localparam logic [ADDR_W-1:0] A_RESET = 7'h07;
    localparam logic [ADDR_W-1:0] A_CONV  = 7'h08;
    localparam logic [ADDR_W-1:0] A_NOP   = 7'h09;

    localparam logic [DATA_W-1:0] CTRL_MASK = 16'h1BC0;
    localparam logic [DATA_W-1:0] OFFS_RST  = 16'h8000;
    localparam logic [DATA_W-1:0] GAIN_RST  = 16'hFFFF;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_DONE  = 2'd2
    } frame_st_e;
endpackage

// File: rtl/spi_dac_frame.sv
module spi_dac_frame
    import spi_dac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  miso,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  frame_ok,
    output logic                  frame_err
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

    logic [2:0] sclk_s;
    logic [2:0] cs_s;
    logic [1:0] mosi_s;
    logic       sclk_rise, sclk_fall, cs_fall, cs_rise;

    frame_st_e             state, state_nx;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] rx_sh, tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_s <= 3'b000;
            cs_s   <= 3'b111;
            mosi_s <= 2'b00;
        end else begin
            sclk_s <= {sclk_s[1:0], sclk};
            cs_s   <= {cs_s[1:0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    assign sclk_rise = sclk_s[1] & ~sclk_s[2];
    assign sclk_fall = ~sclk_s[1] & sclk_s[2];
    assign cs_fall   = ~cs_s[1] & cs_s[2];
    assign cs_rise   = cs_s[1] & ~cs_s[2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE:  if (cs_fall) state_nx = FR_SHIFT;
            FR_SHIFT: if (cs_rise) state_nx = FR_DONE;
            FR_DONE:  state_nx = FR_IDLE;
            default:  state_nx = FR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frame_ok  = 1'b0;
        frame_err = 1'b0;
        if (state == FR_DONE) begin
            frame_ok  = (cnt == CNT_FULL);
            frame_err = (cnt != CNT_FULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
        end else begin
            unique case (state)
                FR_IDLE: if (cs_fall) begin
                    cnt   <= '0;
                    tx_sh <= tx_word;
                end
                FR_SHIFT: begin
                    if (sclk_rise) begin
                        rx_sh <= {rx_sh[FRAME_BITS-2:0], mosi_s[1]};
                        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    end
                    if (sclk_fall) tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                end
                FR_DONE: tx_sh <= '0;
                default: tx_sh <= '0;
            endcase
        end
    end

    assign miso    = tx_sh[FRAME_BITS-1];
    assign rx_word = rx_sh;

    AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_DONE) |=> (state == FR_IDLE)); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX); // R6
endmodule

// File: rtl/spi_dac_regs.sv
module spi_dac_regs
    import spi_dac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_ok,
    input  logic                  frame_err,
    input  logic [FRAME_BITS-1:0] rx_word,
    input  logic [FLT_W-1:0]      fault_in,
    output logic [FRAME_BITS-1:0] tx_word,
    output logic [DATA_W-1:0]     dac_code,
    output logic                  force_alarm,
    output logic                  conv_start,
    output logic                  fault_out
);
    logic                  is_rd;
    logic [ADDR_W-1:0]     addr;
    logic [DATA_W-1:0]     wdata, rdata, flt_word;
    logic [DATA_W-1:0]     dac_q, ctrl_q, offs_q, gain_q;
    logic                  spi_flag;

    assign is_rd    = rx_word[FRAME_BITS-1];
    assign addr     = rx_word[FRAME_BITS-2:DATA_W];
    assign wdata    = rx_word[DATA_W-1:0];
    assign flt_word = {spi_flag, fault_in, {(DATA_W-FLT_W-1){1'b0}}};

    always_comb begin
        case (addr)
            A_DATA:  rdata = dac_q;
            A_CTRL:  rdata = ctrl_q;
            A_OFFS:  rdata = offs_q;
            A_GAIN:  rdata = gain_q;
            A_LDFLT: rdata = flt_word;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_q       <= '0;
            ctrl_q      <= '0;
            offs_q      <= OFFS_RST;
            gain_q      <= GAIN_RST;
            dac_code    <= '0;
            force_alarm <= 1'b0;
            spi_flag    <= 1'b0;
            conv_start  <= 1'b0;
            tx_word     <= '0;
        end else begin
            conv_start <= 1'b0;
            if (frame_err) begin
                spi_flag <= 1'b1;
            end else if (frame_ok) begin
                if (is_rd) begin
                    tx_word <= {{CMD_W{1'b0}}, rdata};
                end else begin
                    tx_word <= '0;
                    case (addr)
                        A_DATA:  dac_q       <= wdata;
                        A_CTRL:  ctrl_q      <= wdata & CTRL_MASK;
                        A_OFFS:  offs_q      <= wdata;
                        A_GAIN:  gain_q      <= wdata;
                        A_LDFLT: dac_code    <= dac_q;
                        A_ALARM: force_alarm <= wdata[0];
                        A_CONV:  conv_start  <= 1'b1;
                        A_RESET: begin
                            dac_q       <= '0;
                            ctrl_q      <= '0;
                            offs_q      <= OFFS_RST;
                            gain_q      <= GAIN_RST;
                            dac_code    <= '0;
                            force_alarm <= 1'b0;
                            spi_flag    <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign fault_out = spi_flag | (|fault_in[FLT_W-1:FLT_W-4]);

    AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> spi_flag); // R6
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && !is_rd && addr == A_LDFLT) |=> (dac_code == $past(dac_q))); // R3
    AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && !is_rd && addr == A_RESET) |=>
        (gain_q == GAIN_RST && offs_q == OFFS_RST && dac_code == '0 && !spi_flag)); // R7
    AST_CONV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R8
endmodule

// File: rtl/spi_dac_regif.sv
module spi_dac_regif
    import spi_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [FLT_W-1:0]  fault_in,
    output logic              miso,
    output logic              fault_out,
    output logic [DATA_W-1:0] dac_code,
    output logic              force_alarm,
    output logic              conv_start
);
    logic [FRAME_BITS-1:0] tx_word, rx_word;
    logic                  frame_ok, frame_err;

    spi_dac_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .tx_word   (tx_word),
        .miso      (miso),
        .rx_word   (rx_word),
        .frame_ok  (frame_ok),
        .frame_err (frame_err)
    );

    spi_dac_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ok    (frame_ok),
        .frame_err   (frame_err),
        .rx_word     (rx_word),
        .fault_in    (fault_in),
        .tx_word     (tx_word),
        .dac_code    (dac_code),
        .force_alarm (force_alarm),
        .conv_start  (conv_start),
        .fault_out   (fault_out)
    );

    AST_OVC_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in[5] |-> fault_out); // R5
endmodule

// File: tb/spi_dac_regif_test.sv
module spi_dac_regif_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic [6:0]  fault_in = '0;
    logic        miso, fault_out, force_alarm, conv_start;
    logic [15:0] dac_code;

    int checks = 0;
    int errors = 0;
    int conv_cnt = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_dac_regif uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .fault_in(fault_in), .miso(miso), .fault_out(fault_out),
        .dac_code(dac_code), .force_alarm(force_alarm), .conv_start(conv_start)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (conv_start) conv_cnt <= conv_cnt + 1;
    end

    initial begin
        wait (cyc > 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected < 190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] w, input int n, output logic [23:0] r);
        r = '0;
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = (i < 24) ? w[23-i] : 1'b0;
            repeat (8) @(negedge clk);
            if (i < 24) r[23-i] = miso;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [23:0] wr(input logic [6:0] a, input logic [15:0] d);
        return {1'b0, a, d};
    endfunction

    function automatic logic [23:0] rd(input logic [6:0] a);
        return {1'b1, a, 16'h0000};
    endfunction

    initial begin
        logic [23:0] r;
        logic [15:0] v, prev;
        logic [6:0]  pf;
        int          c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 reset state
        chk("R10 miso", miso, 0);
        chk("R10 fault_out", fault_out, 0);
        chk("R10 dac_code", dac_code, 0);
        chk("R10 force_alarm", force_alarm, 0);
        chk("R10 conv_start", conv_cnt, 0);

        // R7 default values, R2 pipelined response
        xfer(rd(7'h01), 24, r); chk("R2 first frame", r, 24'h0);
        xfer(rd(7'h04), 24, r); chk("R7 dac default", r, 24'h0);
        xfer(rd(7'h03), 24, r); chk("R7 gain default", r, 24'h00FFFF);
        xfer(rd(7'h02), 24, r); chk("R7 offset default", r, 24'h008000);
        xfer(wr(7'h09, 16'h0), 24, r); chk("R7 ctrl default", r, 24'h0);

        // R1/R2 sweep of DAC data patterns
        prev = '0;
        for (int b = 0; b < 16; b++) begin
            v = (16'h1 << b) ^ 16'h5A3C;
            xfer(wr(7'h01, v), 24, r);
            chk(b == 0 ? "R2 after write" : "R1 dac readback", r, {8'h00, (b == 0) ? 16'h0 : prev});
            xfer(rd(7'h01), 24, r);
            chk("R2 zero after write", r, 24'h0);
            prev = v;
        end
        xfer(wr(7'h09, 16'h0), 24, r); chk("R1 dac readback last", r, {8'h00, prev});
        chk("R3 no load yet", dac_code, 0);
        xfer(wr(7'h05, 16'h0), 24, r);
        chk("R3 load copies", dac_code, prev);

        // R1 control mask, offset, gain
        xfer(wr(7'h02, 16'hFFFF), 24, r);
        xfer(wr(7'h03, 16'h1234), 24, r);
        xfer(wr(7'h04, 16'hBEEF), 24, r);
        xfer(rd(7'h02), 24, r);
        xfer(rd(7'h03), 24, r); chk("R1 ctrl mask", r, 24'h001BC0);
        xfer(rd(7'h04), 24, r); chk("R1 offset", r, 24'h001234);
        xfer(wr(7'h09, 16'h0), 24, r); chk("R1 gain", r, 24'h00BEEF);

        // R8 commands
        xfer(wr(7'h06, 16'h0001), 24, r); chk("R8 alarm set", force_alarm, 1);
        xfer(wr(7'h06, 16'hFFFE), 24, r); chk("R8 alarm clear", force_alarm, 0);
        c0 = conv_cnt;
        xfer(wr(7'h08, 16'h0), 24, r); chk("R8 conv one pulse", conv_cnt, c0 + 1);
        xfer(wr(7'h09, 16'hFFFF), 24, r); chk("R8 nop dac_code", dac_code, prev);
        xfer(rd(7'h01), 24, r);
        xfer(wr(7'h09, 16'h0), 24, r); chk("R8 nop keeps data", r, {8'h00, prev});

        // R9 unmapped
        xfer(rd(7'h0A), 24, r);
        xfer(rd(7'h7F), 24, r); chk("R9 read 0x0A", r, 24'h0);
        xfer(wr(7'h0C, 16'h5555), 24, r); chk("R9 read 0x7F", r, 24'h0);
        xfer(rd(7'h01), 24, r);
        xfer(wr(7'h09, 16'h0), 24, r); chk("R9 unmapped write ignored", r, {8'h00, prev});

        // R6 short frame
        chk("R6 flag clear before", fault_out, 0);
        xfer(wr(7'h01, 16'h1111), 16, r);
        chk("R6 short sets fault_out", fault_out, 1);
        xfer(rd(7'h01), 24, r);
        xfer(rd(7'h05), 24, r); chk("R6 short discarded", r, {8'h00, prev});
        xfer(wr(7'h09, 16'h0), 24, r); chk("R6 flag in fault word", r, 24'h008000);

        // R7 reset command
        xfer(wr(7'h06, 16'h0001), 24, r);
        xfer(wr(7'h07, 16'h0), 24, r);
        chk("R7 dac_code cleared", dac_code, 0);
        chk("R7 alarm cleared", force_alarm, 0);
        chk("R7 flag cleared", fault_out, 0);
        xfer(rd(7'h04), 24, r);
        xfer(rd(7'h03), 24, r); chk("R7 gain restored", r, 24'h00FFFF);
        xfer(rd(7'h02), 24, r); chk("R7 offset restored", r, 24'h008000);
        xfer(wr(7'h09, 16'h0), 24, r); chk("R7 ctrl restored", r, 24'h0);

        // R6 long frame
        xfer(wr(7'h01, 16'h2222), 25, r);
        chk("R6 long sets fault_out", fault_out, 1);
        xfer(rd(7'h01), 24, r);
        xfer(wr(7'h07, 16'h0), 24, r); chk("R6 long discarded", r, 24'h0);
        chk("R6 flag cleared by reset", fault_out, 0);

        // R4/R5 sweep of all fault inputs
        pf = '0;
        for (int k = 0; k < 128; k++) begin
            fault_in = 7'(k);
            repeat (2) @(negedge clk);
            chk("R5 fault_out", fault_out, |fault_in[6:3]);
            xfer(rd(7'h05), 24, r);
            if (k > 0) chk("R4 fault word", r, {8'h00, 1'b0, pf, 8'h00});
            pf = fault_in;
        end
        fault_in = '0;
        xfer(wr(7'h09, 16'h0), 24, r);
        chk("R4 fault word last", r, {8'h00, 1'b0, pf, 8'h00});
        chk("R5 idle fault_out", fault_out, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule